// File: doc/BRIEF.md
# Windowed Link Health Monitor with Escalating Reaction

This block watches the activity of a single-pair vehicle Ethernet link and turns it into a graded health verdict. Its inputs are one-cycle strobes: a frame was received, a frame was in error, the link state toggled, the link retrained, or a wake event occurred. It also takes an optional signal-quality sample. Time is cut into fixed windows of `WIN` cycles. Inside each window the block counts frames, errors, error bursts, link toggles and retrains with saturating counters, and it tracks the lowest quality sample.

At the last cycle of each window four fault conditions are judged: error rate, burst count, link instability and quality. Any fault raises the reaction level one step, from none to warn and then to degrade. The level moves to safe state only once faulty windows have followed one another `Z` times. With latching enabled the level and the fault flags hold until the host clears them. Without latching a clean window lowers the level by one step.

Whenever a burst, retrain, wake or escalation occurs, the block freezes a snapshot of the evidence into a live bank. A host reads the snapshot through a small read port. Reading word 0 copies the whole live bank into a host bank, so the words of one set always belong together.

Top module: `link_health_mon`

## Requirements
- R1: An error strobe counts as one burst when it, together with the error strobes of the preceding T-1 cycles that arrived since the last burst, makes at least M errors; the burst history then restarts empty, so two bursts are never counted in consecutive cycles when M > 1.
- R2: Rate fault (fault_flags bit 0) is set for a window when errors*1000 > RATE_LIM*frames, both counts taken over that window including its last cycle.
- R3: Instability fault (fault_flags bit 2) is set when link toggles in the window exceed FLAP_LIM or retrains exceed RTR_LIM.
- R4: Quality fault (fault_flags bit 3) is set when the smallest valid quality sample in the window is below Q_TH; a window without samples raises no quality fault.
- R5: Reaction level is encoded 0 none, 1 warn, 2 degrade, 3 safe. Each faulty window raises it by one up to 2. It becomes 3 when the count of consecutive faulty windows reaches Z. It changes only at a window end or on clear, and safe_state is high exactly at level 3.
- R6: With latch_en high, level and fault_flags never fall on a clean window, and new faults are OR-ed into the flags. A clr pulse forces level 0, flags 0 and the persistence count 0 on the next edge.
- R7: With latch_en low, a clean window lowers the level by one step, and fault_flags shows only the reasons of the last window.
- R8: All event counters saturate at 2^CNT_W-1 instead of wrapping.
- R9: On a burst, retrain, wake or escalation cycle, the live snapshot takes this cycle's updated counts. The words are: 0 errors, 1 frames, 2 bursts, 3 toggles, 4 retrains. Word 5 is {min quality, 4'b0, cause}, where cause bit 0 is burst, bit 1 retrain, bit 2 wake and bit 3 escalation. Word 6 is the new level and word 7 reads 0.
- R10: rd_data is registered and valid one cycle after rd_en. Reading address 0 returns live word 0 and copies the whole live bank into the host bank. Other addresses return host-bank words, so a later snapshot does not alter a set being read. After reset every word reads 0.
- R11: Burst fault (fault_flags bit 1) is set when bursts in the window exceed BURST_LIM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One frame received |
| err_stb | input | 1 | One frame received in error |
| flap_stb | input | 1 | Link state changed |
| retrain_stb | input | 1 | Link retrain started |
| wake_stb | input | 1 | Wake event observed |
| qual_vld | input | 1 | Quality sample valid |
| qual_smp | input | QW | Quality sample |
| latch_en | input | 1 | Hold level and flags until cleared |
| clr | input | 1 | Clear level, flags and persistence |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Snapshot word address |
| rd_data | output | DW | Snapshot word, one cycle after rd_en |
| level | output | 2 | Reaction level |
| safe_state | output | 1 | High at level 3 |
| fault_flags | output | 4 | Fault reasons: rate, burst, instability, quality |

## Verification
Level, safe_state and fault_flags change on the edge that closes a window, or on the edge that samples clr. They are therefore due one clock after the window's last cycle or after the clr pulse. A snapshot enters the live bank on the edge of its event cycle, and rd_data follows one edge after rd_en. The bench samples every output on the falling edge, after a behavioural model has advanced on the same rising edge that the design used. This keeps each comparison to the cycle in which the result is due. The named checks sit at the falling edge right after the closing edge of a window, and right after each read.

// File: rtl/lhm_pkg.sv
package lhm_pkg;
  typedef enum logic [1:0] {
    LVL_NONE    = 2'd0,
    LVL_WARN    = 2'd1,
    LVL_DEGRADE = 2'd2,
    LVL_SAFE    = 2'd3
  } lvl_e;

  localparam int NUM_CNT   = 5;  // errors, frames, bursts, toggles, retrains
  localparam int NUM_WORDS = 8;  // snapshot words
  localparam int NUM_FLT   = 4;  // rate, burst, instability, quality
endpackage

// File: rtl/lhm_burst.sv
module lhm_burst #(
  parameter int M = 4,
  parameter int T = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_stb,
  output logic burst
);
  localparam int HW = T - 1;

  logic [HW-1:0] hist_q, hist_d;
  int hits;

  always_comb begin
    hits   = $countones(hist_q) + 1;
    burst  = err_stb && (hits >= M);
    hist_d = burst ? '0 : ((hist_q << 1) | HW'(err_stb));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // R1
  burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (M > 1 && burst) |=> !burst);
endmodule

// File: rtl/lhm_cnt.sv
module lhm_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         win_clr,
  output logic [W-1:0] nxt
);
  logic [W-1:0] q;

  always_comb nxt = (inc && (q != '1)) ? q + W'(1) : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= win_clr ? '0 : nxt;
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q == '1 && !win_clr) |=> q == '1);
endmodule

// File: rtl/lhm_react.sv
module lhm_react
  import lhm_pkg::*;
#(
  parameter int Z = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_end,
  input  logic               clr,
  input  logic               latch_en,
  input  logic [NUM_FLT-1:0] fault,
  output lvl_e               lvl,
  output lvl_e               lvl_nxt,
  output logic [NUM_FLT-1:0] flags,
  output logic               esc
);
  localparam int PW = $clog2(Z + 1);

  logic [PW-1:0]      p_q, p_d;
  lvl_e               lvl_q, lvl_d;
  logic [NUM_FLT-1:0] flg_q, flg_d;

  always_comb begin
    lvl_d = lvl_q;
    p_d   = p_q;
    flg_d = flg_q;
    if (clr) begin
      lvl_d = LVL_NONE;
      p_d   = '0;
      flg_d = '0;
    end else if (win_end) begin
      flg_d = latch_en ? (flg_q | fault) : fault;
      if (|fault) begin
        p_d = (p_q == PW'(Z)) ? p_q : p_q + PW'(1);
        if (p_d == PW'(Z) || lvl_q == LVL_SAFE) lvl_d = LVL_SAFE;
        else if (lvl_q == LVL_NONE)             lvl_d = LVL_WARN;
        else                                    lvl_d = LVL_DEGRADE;
      end else begin
        p_d = '0;
        if (!latch_en && lvl_q != LVL_NONE) lvl_d = lvl_e'(lvl_q - 2'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_NONE;
      p_q   <= '0;
      flg_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      p_q   <= p_d;
      flg_q <= flg_d;
    end
  end

  assign lvl     = lvl_q;
  assign lvl_nxt = lvl_d;
  assign flags   = flg_q;
  assign esc     = win_end && !clr && (lvl_d > lvl_q);

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && lvl_q == LVL_SAFE && !clr) |=> lvl_q == LVL_SAFE);

  // R5
  lvl_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && !clr) |=> $stable(lvl_q));
endmodule

// File: rtl/lhm_snap.sv
module lhm_snap #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic [NW-1:0][DW-1:0]  live_in,
  input  logic                   rd_en,
  input  logic [$clog2(NW)-1:0]  rd_addr,
  output logic [DW-1:0]          rd_data
);
  logic [NW-1:0][DW-1:0] lv_q, lv_d, hb_q, hb_d;
  logic [DW-1:0]         rd_q, rd_d;
  logic                  first;

  always_comb begin
    first = rd_en && (rd_addr == '0);
    lv_d  = take ? live_in : lv_q;
    hb_d  = first ? lv_q : hb_q;
    rd_d  = rd_en ? (first ? lv_q[0] : hb_q[rd_addr]) : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q <= '0;
      hb_q <= '0;
      rd_q <= '0;
    end else begin
      lv_q <= lv_d;
      hb_q <= hb_d;
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // R10
  host_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == '0) |=> $stable(hb_q));
endmodule

// File: rtl/link_health_mon.sv
module link_health_mon
  import lhm_pkg::*;
#(
  parameter int WIN       = 1024,
  parameter int CNT_W     = 16,
  parameter int QW        = 8,
  parameter int DW        = 16,
  parameter int M         = 4,
  parameter int T         = 16,
  parameter int FLAP_LIM  = 2,
  parameter int RTR_LIM   = 3,
  parameter int BURST_LIM = 1,
  parameter int Q_TH      = 64,
  parameter int RATE_LIM  = 10,
  parameter int Z         = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_stb,
  input  logic                          err_stb,
  input  logic                          flap_stb,
  input  logic                          retrain_stb,
  input  logic                          wake_stb,
  input  logic                          qual_vld,
  input  logic [QW-1:0]                 qual_smp,
  input  logic                          latch_en,
  input  logic                          clr,
  input  logic                          rd_en,
  input  logic [$clog2(NUM_WORDS)-1:0]  rd_addr,
  output logic [DW-1:0]                 rd_data,
  output logic [1:0]                    level,
  output logic                          safe_state,
  output logic [NUM_FLT-1:0]            fault_flags
);
  localparam int WW = $clog2(WIN);
  localparam int RW = CNT_W + 11;

  logic [WW-1:0] wc_q, wc_d;
  logic          win_end;

  always_comb begin
    win_end = (wc_q == WW'(WIN - 1));
    wc_d    = win_end ? '0 : wc_q + WW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wc_q <= '0;
    else        wc_q <= wc_d;
  end

  logic burst;
  lhm_burst #(.M(M), .T(T)) u_burst (
    .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .burst(burst)
  );

  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_n;
  assign inc = {retrain_stb, flap_stb, burst, frame_stb, err_stb};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    lhm_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc[g]), .win_clr(win_end), .nxt(cnt_n[g])
    );
  end

  logic [QW-1:0] qmin_q, qmin_n;
  always_comb qmin_n = (qual_vld && qual_smp < qmin_q) ? qual_smp : qmin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qmin_q <= '1;
    else        qmin_q <= win_end ? '1 : qmin_n;
  end

  logic [RW-1:0]      rate_lhs, rate_rhs;
  logic [NUM_FLT-1:0] fault;
  always_comb begin
    rate_lhs = RW'(cnt_n[0]) * RW'(1000);
    rate_rhs = RW'(cnt_n[1]) * RW'(RATE_LIM);
    fault[0] = rate_lhs > rate_rhs;
    fault[1] = cnt_n[2] > CNT_W'(BURST_LIM);
    fault[2] = (cnt_n[3] > CNT_W'(FLAP_LIM)) || (cnt_n[4] > CNT_W'(RTR_LIM));
    fault[3] = qmin_n < QW'(Q_TH);
  end

  lvl_e lvl, lvl_nxt;
  logic esc;
  lhm_react #(.Z(Z)) u_react (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .clr(clr), .latch_en(latch_en),
    .fault(fault), .lvl(lvl), .lvl_nxt(lvl_nxt), .flags(fault_flags), .esc(esc)
  );

  logic [3:0]                    cause;
  logic [NUM_WORDS-1:0][DW-1:0]  live;
  always_comb begin
    cause = {esc, wake_stb, retrain_stb, burst};
    for (int k = 0; k < NUM_CNT; k++) live[k] = DW'(cnt_n[k]);
    live[5] = DW'({qmin_n, 4'b0000, cause});
    live[6] = DW'(lvl_nxt);
    live[7] = '0;
  end

  lhm_snap #(.DW(DW), .NW(NUM_WORDS)) u_snap (
    .clk(clk), .rst_n(rst_n), .take(|cause), .live_in(live),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign level      = lvl;
  assign safe_state = (lvl == LVL_SAFE);

  // R5
  safe_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    safe_state |-> level == 2'd3);
endmodule

// File: tb/link_health_mon_tb.sv
`timescale 1ns/1ps
module link_health_mon_tb;
  localparam int WIN = 64, CNT_W = 6, M = 3, T = 8;
  localparam int FL = 2, RL = 2, BL = 1, QTH = 100, RATE = 50, Z = 4;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_stb = 0, err_stb = 0, flap_stb = 0, retrain_stb = 0, wake_stb = 0;
  logic qual_vld = 0, latch_en = 0, clr = 0, rd_en = 0;
  logic [7:0] qual_smp = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [15:0] rd_data;
  logic [1:0] level;
  logic safe_state;
  logic [3:0] fault_flags;

  always #2 clk = ~clk;

  link_health_mon #(.WIN(WIN), .CNT_W(CNT_W), .QW(8), .DW(16), .M(M), .T(T),
    .FLAP_LIM(FL), .RTR_LIM(RL), .BURST_LIM(BL), .Q_TH(QTH), .RATE_LIM(RATE), .Z(Z)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .err_stb(err_stb), .flap_stb(flap_stb),
    .retrain_stb(retrain_stb), .wake_stb(wake_stb), .qual_vld(qual_vld), .qual_smp(qual_smp),
    .latch_en(latch_en), .clr(clr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .level(level), .safe_state(safe_state), .fault_flags(fault_flags));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_wc, m_err, m_frm, m_bur, m_flp, m_rtr, m_qmin, m_cyc, m_lvl, m_p, m_flg, m_rd;
  int m_live[8], m_host[8];
  int errq[$];

  function automatic int sat(int x);
    return (x > MAXC) ? MAXC : x;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wc = 0; m_err = 0; m_frm = 0; m_bur = 0; m_flp = 0; m_rtr = 0; m_qmin = 255;
      m_cyc = 0; m_lvl = 0; m_p = 0; m_flg = 0; m_rd = 0;
      foreach (m_live[k]) begin m_live[k] = 0; m_host[k] = 0; end
      errq.delete();
    end else begin : step
      int b, e, fr, bu, f, r, q, fl, old, esc;
      bit fin;
      m_cyc++;
      b = 0;
      if (err_stb) begin
        while (errq.size() > 0 && errq[0] < m_cyc - (T - 1)) void'(errq.pop_front());
        errq.push_back(m_cyc);
        if (errq.size() >= M) begin b = 1; errq.delete(); end
      end
      e  = sat(m_err + err_stb);  fr = sat(m_frm + frame_stb); bu = sat(m_bur + b);
      f  = sat(m_flp + flap_stb); r  = sat(m_rtr + retrain_stb);
      q  = (qual_vld && qual_smp < m_qmin) ? qual_smp : m_qmin;
      fin = (m_wc == WIN - 1);
      if (rd_en) begin
        if (rd_addr == 0) begin m_rd = m_live[0]; m_host = m_live; end
        else m_rd = m_host[rd_addr];
      end
      fl = ((e * 1000 > RATE * fr) ? 1 : 0) | ((bu > BL) ? 2 : 0) |
           ((f > FL || r > RL) ? 4 : 0) | ((q < QTH) ? 8 : 0);
      old = m_lvl;
      if (clr) begin m_lvl = 0; m_p = 0; m_flg = 0; end
      else if (fin) begin
        m_flg = latch_en ? (m_flg | fl) : fl;
        if (fl != 0) begin
          m_p = (m_p < Z) ? m_p + 1 : Z;
          if (m_p >= Z || m_lvl == 3) m_lvl = 3;
          else m_lvl = (m_lvl == 0) ? 1 : 2;
        end else begin
          m_p = 0;
          if (!latch_en && m_lvl > 0) m_lvl--;
        end
      end
      esc = (fin && !clr && m_lvl > old) ? 1 : 0;
      if (b || retrain_stb || wake_stb || esc) begin
        m_live[0] = e; m_live[1] = fr; m_live[2] = bu; m_live[3] = f; m_live[4] = r;
        m_live[5] = (q << 8) | (esc << 3) | (wake_stb << 2) | (retrain_stb << 1) | b;
        m_live[6] = m_lvl; m_live[7] = 0;
      end
      if (fin) begin m_err = 0; m_frm = 0; m_bur = 0; m_flp = 0; m_rtr = 0; m_qmin = 255; end
      else begin m_err = e; m_frm = fr; m_bur = bu; m_flp = f; m_rtr = r; m_qmin = q; end
      m_wc = fin ? 0 : m_wc + 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5/R6/R7 level", level, m_lvl);
      chk("R5 safe_state", safe_state, (m_lvl == 3) ? 1 : 0);
      chk("R2/R3/R4/R11 fault_flags", fault_flags, m_flg);
      chk("R9/R10 rd_data", rd_data, m_rd);
    end
  end

  task automatic align();
    while (m_wc != 0) @(negedge clk);
  endtask

  task automatic run_win(int mode);
    for (int i = 0; i < WIN; i++) begin
      frame_stb = 0; err_stb = 0; flap_stb = 0; retrain_stb = 0; wake_stb = 0; qual_vld = 0;
      case (mode)
        0: begin frame_stb = (i % 2 == 0); qual_vld = (i % 8 == 0); qual_smp = 8'd200; end
        1: begin frame_stb = 1; err_stb = (i % 10 == 5); end
        2: begin frame_stb = 1; err_stb = (i inside {10, 11, 12, 40, 41, 42}); end
        3: begin flap_stb = (i inside {5, 20, 35}); retrain_stb = (i == 7); end
        4: begin qual_vld = (i % 6 == 0); qual_smp = (i == 30) ? 8'd50 : 8'd200; end
        default: begin frame_stb = 1; wake_stb = (i == WIN - 1); end
      endcase
      @(negedge clk);
    end
    frame_stb = 0; err_stb = 0; flap_stb = 0; retrain_stb = 0; wake_stb = 0; qual_vld = 0;
  endtask

  task automatic rd(int a, output int v);
    rd_en = 1; rd_addr = 3'(a);
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic pulse_clr();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    chk("R10 reset rd_data", rd_data, 0);
    chk("R5 reset level", level, 0);
    chk("R6 reset fault_flags", fault_flags, 0);
    rst_n = 1;
    @(negedge clk);
    align();
    run_win(0); chk("R5 clean window level", level, 0);
    run_win(1); chk("R2 rate flag", fault_flags, 1); chk("R5 first fault warn", level, 1);
    run_win(2); chk("R1 R11 burst and rate flags", fault_flags, 3); chk("R5 degrade", level, 2);
    run_win(3); chk("R3 instability flag only", fault_flags, 4); chk("R5 degrade held below Z", level, 2);
    run_win(4); chk("R4 quality flag", fault_flags, 8); chk("R5 safe at Z", level, 3);
    chk("R5 safe_state", safe_state, 1);
    run_win(0); chk("R7 clean window steps down", level, 2); chk("R7 flags cleared", fault_flags, 0);
    rd(0, v); chk("R9 word0 errors", v, 0);
    rd(5, v); chk("R9 word5 qmin and escalation cause", v, 16'h3208);
    rd(6, v); chk("R9 word6 level", v, 3);
    pulse_clr(); chk("R6 clr level", level, 0); chk("R6 clr flags", fault_flags, 0);
    latch_en = 1;
    align();
    run_win(4); chk("R6 latched warn", level, 1);
    run_win(0); chk("R6 level held on clean window", level, 1); chk("R6 flags held", fault_flags, 8);
    pulse_clr(); chk("R6 clr after latch", level, 0);
    latch_en = 0;
    align();
    run_win(5);
    rd(0, v); chk("R9 word0 after wake", v, 0);
    rd(1, v); chk("R8 frame count saturates", v, MAXC);
    retrain_stb = 1; @(negedge clk); retrain_stb = 0;
    rd(4, v); chk("R10 host bank unchanged by new snapshot", v, 0);
    rd(0, v);
    rd(4, v); chk("R10 fresh set after word0 read", v, 1);
    rd(7, v); chk("R9 word7 zero", v, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    done = 1;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule